// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave with Page Staging

This block is the bus-facing half of a small byte memory (256 locations by default) that sits on a two-wire serial bus as a slave. It watches the clock and data lines of the bus in its own system clock domain and recognises START and STOP conditions. It checks a 7-bit device address that carries a read/write flag. It accepts a one-byte word address that loads its internal pointer. After that it either takes write data or returns read data. The data line is open-drain. The block only ever pulls it low, through `sda_oe`, and reads the wired level back on `sda_in`.

Writes do not go straight into the array. Each received byte lands in a page buffer whose size is a power of two, indexed by the low bits of the pointer. Only those low bits advance between bytes, so a long burst wraps inside its page and overwrites bytes it already staged. When the master issues STOP, the staged bytes are copied into the array in one step. A programming window of `WRITE_CYCLES` system clocks then begins, and during it the block answers nothing on the bus. Reads stream bytes out of the array, advancing the pointer across the whole address space, for as long as the master acknowledges.

The block has no streaming port at its edge; the bus lines and the busy flag are plain pins. Inside, the protocol engine hands bytes to the page buffer on a valid/ready pair. Ready is low only during the programming window, and the protocol engine never offers a byte then, because it has refused the device address.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A falling data line while the clock line is high is a START, and a rising data line while the clock is high is a STOP. A START at any point, including the middle of a byte, restarts address reception. A STOP at any point releases the data line and returns the block to idle.
- R2: After a START, the first byte is the 7-bit device address, MSB first, followed by the read/write flag (1 = read). On a match with `DEV_ADDR`, the block pulls the data line low for the whole ninth clock. On a mismatch it leaves the line released.
- R3: In a write (flag 0), the byte after the device address loads the pointer, and that byte and every data byte after it are acknowledged on their ninth clock.
- R4: Between write data bytes, only the low log2(`PAGE_BYTES`) bits of the pointer advance. With 16-byte pages, a burst of 17 bytes starting at 0x23 writes 0x23..0x2F, then 0x20..0x23, so the 17th byte replaces the 1st. Address 0x30 is left untouched.
- R5: Staged bytes reach the array only after STOP. `busy` rises on the STOP and stays high for exactly `WRITE_CYCLES` system clocks. Before the STOP, `busy` stays low.
- R6: While `busy` is high, the block acknowledges no byte, including its own device address.
- R7: A STOP that follows the word address with no complete data byte starts no programming window. The pointer keeps the loaded value.
- R8: In a read (flag 1), the block drives the byte at the pointer MSB first and releases the line on the ninth clock. The pointer advances by one across the full address space, wrapping from 0xFF to 0x00. An acknowledge (line low on the ninth clock) makes it send the next byte.
- R9: A not-acknowledge on the ninth clock of a read ends the transfer. The block then leaves the line released for any further clocks until the next START.
- R10: A read that is not preceded by a word address starts at the current pointer, which is the address after the last byte read, or the value loaded by the last word address.
- R11: A START that arrives in place of a STOP discards all bytes staged since the last commit. This applies both mid-byte and after complete data bytes, so a later STOP commits nothing.
- R12: After reset, the data line is released, `busy` is low, and every memory location reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bus lines are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Serial clock line level as seen at the pin |
| sda_in | input | 1 | Wired level of the serial data line |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| busy | output | 1 | High during the internal programming window |

## Verification
The hardest situation to reach from the pins is a bus transaction that overlaps the programming window. The window is only a few hundred system clocks long in the bench. A complete address byte takes about 180 clocks, so the stimulus issues a new START and the block's own address immediately after the STOP that began the window. It then checks for a not-acknowledge while `busy` is still high, and it still measures the full length of the window. The in-page wrap and the mid-byte abort are reached in a similar way. A burst one byte longer than a page is followed by a read that spans the page and the first byte of the next one. A START is inserted after four bits of a data byte, and the affected locations are read back afterwards.

// File: rtl/i2c_ee_pkg.sv
`timescale 1ns/1ps
package i2c_ee_pkg;

  // protocol engine states
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a START
    ST_DEV,    // shifting in the device address byte
    ST_WADR,   // shifting in the word address byte
    ST_WDAT,   // shifting in write data bytes
    ST_ACK,    // pulling the line low for the ninth clock
    ST_TX,     // driving read data bits
    ST_RACK,   // sampling the master's acknowledge
    ST_WSTOP   // released, waiting for the next START or STOP
  } ee_state_e;

endpackage

// File: rtl/i2c_ee_sync.sv
`timescale 1ns/1ps
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_p, sda_p;

  // idle bus is high, so every stage resets high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl};
      sda_q <= {sda_q[STAGES-2:0], sda};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  =  scl_s & ~scl_p;
  assign scl_fall  = ~scl_s &  scl_p;
  assign start_det =  scl_s &  scl_p &  sda_p & ~sda_s;
  assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_s;

endmodule

// File: rtl/i2c_ee_store.sv
`timescale 1ns/1ps
module i2c_ee_store #(
  parameter int ADDR_W       = 8,
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              discard,
  input  logic              commit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int HI_W   = ADDR_W - PAGE_W;
  localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);

  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PAGE_N];
  logic [PAGE_N-1:0] vmask;
  logic [HI_W-1:0]   page;
  logic [CNT_W-1:0]  prog_cnt;

  assign busy     = (prog_cnt != '0);
  assign wr_ready = ~busy;
  assign rd_data  = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE_N; i++) pbuf[i] <= 8'h00;
      vmask    <= '0;
      page     <= '0;
      prog_cnt <= '0;
    end else begin
      if (busy) prog_cnt <= prog_cnt - CNT_W'(1);
      if (commit && (vmask != '0) && !busy) begin
        // copy every staged byte of the page into the array at once
        for (int i = 0; i < PAGE_N; i++)
          if (vmask[i]) mem[{page, PAGE_W'(i)}] <= pbuf[i];
        vmask    <= '0;
        prog_cnt <= CNT_W'(WRITE_CYCLES);
      end else if (discard) begin
        vmask <= '0;
      end else if (wr_valid && wr_ready) begin
        pbuf[wr_addr[PAGE_W-1:0]]  <= wr_data;
        vmask[wr_addr[PAGE_W-1:0]] <= 1'b1;
        page                       <= wr_addr[ADDR_W-1:PAGE_W];
      end
    end
  end

  // R5: a programming window only ever opens right after a commit request
  a_r5_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit));

  // R7: a commit request with nothing staged leaves the block idle
  a_r7_empty_commit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (vmask == '0) && !busy) |=> !busy);

  // R4: every staged byte of one burst shares the same high address bits
  a_r4_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (vmask != '0)) |-> (wr_addr[ADDR_W-1:PAGE_W] == page));

endmodule

// File: rtl/i2c_eeprom_slave.sv
`timescale 1ns/1ps
module i2c_eeprom_slave
  import i2c_ee_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR     = 7'h50,
  parameter int         ADDR_W       = 8,
  parameter int         PAGE_BYTES   = 16,
  parameter int         WRITE_CYCLES = 1000,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda_in,
  output logic sda_oe,
  output logic busy
);

  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ee_state_e         st, nxt;
  logic [7:0]        sh;
  logic [3:0]        bitcnt;
  logic [ADDR_W-1:0] ptr;
  logic              got_ack;
  logic              oe;
  logic              wr_valid, wr_ready;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic [7:0]        rd_data;

  i2c_ee_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .discard(start_det), .commit(stop_det),
    .rd_addr(ptr), .rd_data(rd_data), .busy(busy)
  );

  assign sda_oe = oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      nxt      <= ST_IDLE;
      sh       <= '0;
      bitcnt   <= '0;
      ptr      <= '0;
      got_ack  <= 1'b0;
      oe       <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (start_det) begin
        st     <= ST_DEV;
        bitcnt <= '0;
        oe     <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE;
        oe <= 1'b0;
      end else begin
        unique case (st)
          ST_DEV, ST_WADR, ST_WDAT: begin
            if (scl_rise) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (st == ST_DEV) begin
                if (sh[7:1] == DEV_ADDR && !busy) begin
                  oe  <= 1'b1;
                  nxt <= sh[0] ? ST_TX : ST_WADR;
                  st  <= ST_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_WADR) begin
                ptr <= ADDR_W'(sh);
                oe  <= 1'b1;
                nxt <= ST_WDAT;
                st  <= ST_ACK;
              end else begin
                wr_valid          <= 1'b1;
                wr_addr           <= ptr;
                wr_data           <= sh;
                ptr[PAGE_W-1:0]   <= ptr[PAGE_W-1:0] + PAGE_W'(1);
                oe                <= 1'b1;
                nxt               <= ST_WDAT;
                st                <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (nxt == ST_TX) begin
                sh     <= rd_data;
                oe     <= ~rd_data[7];
                ptr    <= ptr + ADDR_W'(1);
                bitcnt <= 4'd1;
                st     <= ST_TX;
              end else begin
                oe <= 1'b0;
                st <= nxt;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                oe <= 1'b0;
                st <= ST_RACK;
              end else begin
                oe     <= ~sh[6];
                sh     <= {sh[6:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              got_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (got_ack) begin
                sh     <= rd_data;
                oe     <= ~rd_data[7];
                ptr    <= ptr + ADDR_W'(1);
                bitcnt <= 4'd1;
                st     <= ST_TX;
              end else begin
                st <= ST_WSTOP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: a START always leads back to device address reception with the line released
  a_r1_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_DEV && !sda_oe));

  // R1: a STOP always releases the data line
  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R2: the line is only ever pulled while the bus clock is low
  a_r2_pull_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  // R6: silent on the bus for the whole programming window
  a_r6_silent_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R6: no byte is handed to the page buffer while it cannot take it
  a_r6_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_ready);

  // R9: after a not-acknowledge the line stays released
  a_r9_released_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WSTOP) |-> !sda_oe);

endmodule

// File: tb/tb_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module tb_i2c_eeprom_slave;

  localparam int         WC  = 400;
  localparam logic [6:0] DEV = 7'h50;
  localparam time        Q   = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, busy;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  i2c_eeprom_slave #(.DEV_ADDR(DEV), .WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda_in(sda_bus),
    .sda_oe(sda_oe), .busy(busy)
  );

  int errors = 0;
  int checks = 0;
  int busy_seen = 0;
  logic done = 1'b0;
  logic [7:0] rb [24];

  always @(negedge clk) if (busy) busy_seen++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #(Q);
    scl = 1'b1;   #(2*Q);
    sda_m = 1'b0; #(2*Q);
    scl = 1'b0;   #(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #(Q);
    scl = 1'b1;   #(2*Q);
    sda_m = 1'b1; #(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; #(Q);
      scl = 1'b1;   #(2*Q);
      scl = 1'b0;   #(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; #(Q);
    scl = 1'b1;   #(Q);
    ack = ~sda_bus;
    #(Q);
    scl = 1'b0;   #(Q);
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #(Q); scl = 1'b1; #(Q);
      b[i] = sda_bus;
      #(Q); scl = 1'b0; #(Q);
    end
    sda_m = ~mack; #(Q);
    scl = 1'b1;    #(2*Q);
    scl = 1'b0;    #(Q);
    sda_m = 1'b1;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // START, device address for write, word address, data bytes, STOP
  task automatic write_burst(input logic [7:0] addr, input int n, input logic [7:0] base);
    logic a;
    bus_start();
    send_byte({DEV, 1'b0}, a); chk("R2 device address ack", a, 1);
    send_byte(addr, a);        chk("R3 word address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(base + 8'(i), a); chk("R3 data byte ack", a, 1);
    end
    @(negedge clk); chk("R5 busy low before STOP", busy, 0);
    busy_seen = 0;
    bus_stop();
  endtask

  // random read: dummy write of the address, repeated START, n bytes
  task automatic read_from(input logic [7:0] addr, input int n);
    logic a;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(addr, a);
    bus_start();
    send_byte({DEV, 1'b1}, a); chk("R8 read address ack", a, 1);
    for (int i = 0; i < n; i++) get_byte(i != n - 1, rb[i]);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R12 line released after reset", sda_oe, 0);
    chk("R12 busy low after reset", busy, 0);
    read_from(8'h77, 1);
    chk("R12 erased content", rb[0], 8'hFF);
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start();
    send_byte({7'h51, 1'b0}, a);
    chk("R2 no ack for other address", a, 0);
    bus_stop();
  endtask

  task automatic t_byte_write();
    logic a;
    write_burst(8'h10, 1, 8'hA5);
    chk("R5 busy after STOP", busy, 1);
    bus_start();
    send_byte({DEV, 1'b0}, a);
    chk("R6 own address refused while busy", a, 0);
    chk("R6 probe landed inside window", busy, 1);
    bus_stop();
    wait_idle();
    chk("R5 window length", busy_seen, WC);
    read_from(8'h10, 1);
    chk("R8 byte read back", rb[0], 8'hA5);
  endtask

  task automatic t_page_wrap();
    logic [7:0] exp;
    write_burst(8'h23, 17, 8'h60);
    wait_idle();
    read_from(8'h20, 17);
    for (int i = 0; i < 16; i++) begin
      // burst byte k lands at 0x20 + ((3 + k) mod 16); the 17th wins at 0x23
      if (i == 3) exp = 8'h70;
      else exp = 8'h60 + 8'((i + 13) % 16);
      chk("R4 page wrap content", rb[i], exp);
    end
    chk("R4 next page untouched", rb[16], 8'hFF);
  endtask

  task automatic t_read_wrap();
    write_burst(8'hFE, 2, 8'hC1);
    wait_idle();
    read_from(8'hFE, 3);
    chk("R8 byte at 0xFE", rb[0], 8'hC1);
    chk("R8 byte at 0xFF", rb[1], 8'hC2);
    chk("R8 pointer wraps to 0x00", rb[2], 8'hFF);
  endtask

  task automatic t_current_ptr();
    logic a;
    write_burst(8'h50, 2, 8'h3C);
    wait_idle();
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h50, a);
    busy_seen = 0;
    bus_stop();
    repeat (20) @(negedge clk);
    chk("R7 no window without data", busy_seen, 0);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    get_byte(1'b0, rb[0]);
    bus_stop();
    chk("R10 read at loaded pointer", rb[0], 8'h3C);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    get_byte(1'b0, rb[1]);
    bus_stop();
    chk("R10 read continues after last byte", rb[1], 8'h3D);
  endtask

  task automatic t_nack_release();
    logic a;
    read_from(8'h10, 1);
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h10, a);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    get_byte(1'b0, rb[0]);
    get_byte(1'b0, rb[1]);
    bus_stop();
    chk("R9 byte before nack", rb[0], 8'hA5);
    chk("R9 line released after nack", rb[1], 8'hFF);
  endtask

  task automatic t_abort();
    logic a;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h40, a);
    send_byte(8'h11, a);
    chk("R11 full byte acked before abort", a, 1);
    send_bits(8'h20, 4);
    bus_start();
    busy_seen = 0;
    bus_stop();
    repeat (20) @(negedge clk);
    chk("R11 no window after abort", busy_seen, 0);
    chk("R1 line released after STOP", sda_oe, 0);
    read_from(8'h40, 1);
    chk("R11 staged byte discarded", rb[0], 8'hFF);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_bad_addr();
    t_byte_write();
    t_page_wrap();
    t_read_wrap();
    t_current_ptr();
    t_nack_release();
    t_abort();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(150000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule